// File: doc/BRIEF.md
# Per-Port Detection and Classification Scheduler

This block schedules load detection and load classification routines on four ports. It holds one control register of eight bits: a detection enable and a classification enable for each port. It turns the enabled bits into start pulses toward a measurement engine, one per port, and then waits for that engine's done pulse before it treats the port as free again. The measurement itself is done outside the block.

The block has three operating modes, selected by a 2-bit input. In manual mode each enable bit acts as a pushbutton. Setting the bit launches the routine once, and the bit drops back to zero when the routine completes. Software polls the register to see when the routine has finished. In semi and auto modes the bits stay set, and the enabled routines run again each time the port becomes idle. Changing the mode reloads the register with that mode's default. A reset fills every bit with the level of a strap input.

Top module: `probe_sched`

## Requirements
- R1: While reset is asserted, and at the first clock after its release, every register bit equals `strap_auto_i`, and no start pulse is issued during reset.
- R2: The bit layout is fixed. For port p (0..3), bit p enables detection and bit 4+p enables classification. `cfg_rdata_o` always shows the live register value. A write, when it is applied, is visible on `cfg_rdata_o` one clock after `cfg_we_i`.
- R3: On an idle port with both bits set, detection is started first (`start_cls_o[p]`=0). Classification follows only after the detection's done pulse.
- R4: On a port whose classification bit is set and whose detection bit is clear, the block starts classification (`start_cls_o[p]`=1).
- R5: Mode code 2'b00 is manual mode. In this mode, when a routine's done pulse arrives, the bit of that routine is cleared.
- R6: Mode code 2'b01 is semi mode, and codes 2'b10 and 2'b11 are auto mode. In these modes, completion clears no bit. Each port repeats its enabled routines, and when both bits are set it alternates between detection and classification.
- R7: A change of `mode_i` loads the register on the next clock. Auto loads all ones; semi and manual load all zeros. The mode seen at the first clock after reset loads nothing. A mode load takes priority over a write in the same cycle.
- R8: At most one start pulse is issued per clock. Idle ports that request are granted in round-robin order that rises from port 0, and port 0 is first after reset. A start is issued on the clock after the port's enable bits become visible.
- R9: Each port has at most one routine in flight. `start_o[p]` is a single-cycle pulse. A done pulse on a port with nothing in flight has no effect.
- R10: A write made while a port's routine is in flight leaves that port's bits unchanged until the done pulse. At the done pulse the written bits replace the port's bits, and they are not cleared by that completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| strap_auto_i | input | 1 | Latched strap level copied into every bit at reset |
| mode_i | input | 2 | Operating mode: 00 manual, 01 semi, 1x auto |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_wdata_i | input | 8 | Register write data |
| cfg_rdata_o | output | 8 | Live register value |
| start_o | output | 4 | Per-port start pulse toward the measurement engine |
| start_cls_o | output | 4 | Routine kind qualifying start_o: 1 classification, 0 detection |
| done_i | input | 4 | Per-port completion pulse from the measurement engine |

## Verification
The assertions run on every cycle. They check the following:
- The register value at the release of reset.
- That no more than one start is issued in a cycle.
- That each start is a single-cycle pulse and goes only to a port that was idle.
- That each start's kind matches an enable bit that was set one cycle earlier.
- The register value after each mode load.

Some behaviours need the bench's scenarios and its cycle-by-cycle reference model:
- Detection coming before classification.
- The pushbutton clearing in manual mode.
- The alternation in semi and auto modes.
- Writes that are deferred while a routine is in flight.
- The round-robin order.
- Done pulses on an idle port being ignored.

// File: rtl/probe_sched_pkg.sv
package probe_sched_pkg;

  typedef enum logic [1:0] {
    MODE_MANUAL   = 2'b00,
    MODE_SEMI     = 2'b01,
    MODE_AUTO     = 2'b10,
    MODE_AUTO_ALT = 2'b11
  } op_mode_e;

  // Upper mode bit selects the all-ones default.
  function automatic logic mode_loads_ones(input logic [1:0] m);
    return m[1];
  endfunction

  // Only manual mode makes enable bits self-clearing.
  function automatic logic mode_self_clears(input logic [1:0] m);
    return m == MODE_MANUAL;
  endfunction

endpackage

// File: rtl/probe_sched_mode.sv
module probe_sched_mode
  import probe_sched_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  output logic       load_o,
  output logic       load_ones_o,
  output logic       self_clr_o
);

  logic [1:0] mode_q;
  logic       seen_q;

  // seen_q masks the first edge after reset so the strap value survives.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_MANUAL;
      seen_q <= 1'b0;
    end else begin
      mode_q <= mode_i;
      seen_q <= 1'b1;
    end
  end

  always_comb begin
    load_o      = seen_q && (mode_i != mode_q);
    load_ones_o = mode_loads_ones(mode_i);
    self_clr_o  = mode_self_clears(mode_i);
  end

endmodule

// File: rtl/probe_sched_arb.sv
module probe_sched_arb #(
  parameter  int NREQ = 4,
  localparam int IW   = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] req_i,
  output logic [NREQ-1:0] gnt_o
);

  logic [IW-1:0] last_q;
  logic [IW-1:0] win_idx;
  logic          found;

  // Search starts one past the last winner and wraps around.
  always_comb begin
    gnt_o   = '0;
    found   = 1'b0;
    win_idx = last_q;
    for (int k = 1; k <= NREQ; k++) begin
      int idx;
      idx = (int'(last_q) + k) % NREQ;
      if (!found && req_i[idx]) begin
        found      = 1'b1;
        gnt_o[idx] = 1'b1;
        win_idx    = IW'(idx);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= IW'(NREQ - 1);
    end else if (found) begin
      last_q <= win_idx;
    end
  end

endmodule

// File: rtl/probe_sched_port.sv
module probe_sched_port (
  input  logic clk,
  input  logic rst_n,
  input  logic strap_i,
  input  logic load_i,
  input  logic load_val_i,
  input  logic self_clr_i,
  input  logic wr_i,
  input  logic wr_det_i,
  input  logic wr_cls_i,
  input  logic grant_i,
  input  logic done_i,
  output logic det_o,
  output logic cls_o,
  output logic want_o,
  output logic busy_o,
  output logic start_o,
  output logic start_cls_o
);

  logic det_q, cls_q;
  logic busy_q, cur_cls_q, nxt_cls_q;
  logic pend_q, pend_det_q, pend_cls_q;
  logic start_q, start_cls_q;

  logic finish, wr_now, wr_defer, kind_cls;
  logic det_n, cls_n, nxt_n;

  always_comb begin
    finish   = busy_q & done_i;
    wr_now   = wr_i & (~busy_q | finish);
    wr_defer = wr_i & busy_q & ~finish;
    // Detection wins unless the port just finished one.
    kind_cls = cls_q & (~det_q | nxt_cls_q);
    want_o   = ~busy_q & (det_q | cls_q);
  end

  // Bit update priority: mode load, direct write, deferred write, self-clear.
  always_comb begin
    det_n = det_q;
    cls_n = cls_q;
    nxt_n = nxt_cls_q;
    if (finish) begin
      nxt_n = ~cur_cls_q;
      if (self_clr_i) begin
        if (cur_cls_q) cls_n = 1'b0;
        else           det_n = 1'b0;
      end
    end
    if (finish && pend_q) begin
      det_n = pend_det_q;
      cls_n = pend_cls_q;
      nxt_n = 1'b0;
    end
    if (wr_now) begin
      det_n = wr_det_i;
      cls_n = wr_cls_i;
      nxt_n = 1'b0;
    end
    if (load_i) begin
      det_n = load_val_i;
      cls_n = load_val_i;
      nxt_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det_q     <= strap_i;
      cls_q     <= strap_i;
      nxt_cls_q <= 1'b0;
    end else begin
      det_q     <= det_n;
      cls_q     <= cls_n;
      nxt_cls_q <= nxt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      pend_det_q <= 1'b0;
      pend_cls_q <= 1'b0;
    end else if (load_i) begin
      pend_q <= 1'b0;
    end else if (wr_defer) begin
      pend_q     <= 1'b1;
      pend_det_q <= wr_det_i;
      pend_cls_q <= wr_cls_i;
    end else if (finish) begin
      pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      cur_cls_q   <= 1'b0;
      start_q     <= 1'b0;
      start_cls_q <= 1'b0;
    end else begin
      start_q     <= grant_i;
      start_cls_q <= grant_i & kind_cls;
      if (grant_i) begin
        busy_q    <= 1'b1;
        cur_cls_q <= kind_cls;
      end else if (finish) begin
        busy_q <= 1'b0;
      end
    end
  end

  always_comb begin
    det_o       = det_q;
    cls_o       = cls_q;
    busy_o      = busy_q;
    start_o     = start_q;
    start_cls_o = start_cls_q;
  end

endmodule

// File: rtl/probe_sched.sv
module probe_sched #(
  parameter  int NPORTS = 4,
  localparam int REGW   = 2 * NPORTS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_auto_i,
  input  logic [1:0]        mode_i,
  input  logic              cfg_we_i,
  input  logic [REGW-1:0]   cfg_wdata_i,
  output logic [REGW-1:0]   cfg_rdata_o,
  output logic [NPORTS-1:0] start_o,
  output logic [NPORTS-1:0] start_cls_o,
  input  logic [NPORTS-1:0] done_i
);

  logic              mode_load, load_ones, self_clr;
  logic [NPORTS-1:0] want, grant, busy, det_bits, cls_bits;

  probe_sched_mode u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .load_o      (mode_load),
    .load_ones_o (load_ones),
    .self_clr_o  (self_clr)
  );

  probe_sched_arb #(.NREQ(NPORTS)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req_i (want),
    .gnt_o (grant)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    probe_sched_port u_port (
      .clk         (clk),
      .rst_n       (rst_n),
      .strap_i     (strap_auto_i),
      .load_i      (mode_load),
      .load_val_i  (load_ones),
      .self_clr_i  (self_clr),
      .wr_i        (cfg_we_i),
      .wr_det_i    (cfg_wdata_i[p]),
      .wr_cls_i    (cfg_wdata_i[NPORTS+p]),
      .grant_i     (grant[p]),
      .done_i      (done_i[p]),
      .det_o       (det_bits[p]),
      .cls_o       (cls_bits[p]),
      .want_o      (want[p]),
      .busy_o      (busy[p]),
      .start_o     (start_o[p]),
      .start_cls_o (start_cls_o[p])
    );
  end

  assign cfg_rdata_o = {cls_bits, det_bits};

endmodule

// File: rtl/probe_sched_chk.sv
module probe_sched_chk #(
  parameter  int NPORTS = 4,
  localparam int REGW   = 2 * NPORTS
) (
  input logic              clk,
  input logic              rst_n,
  input logic              strap_auto_i,
  input logic [1:0]        mode_i,
  input logic [REGW-1:0]   cfg_rdata_o,
  input logic [NPORTS-1:0] start_o,
  input logic [NPORTS-1:0] start_cls_o,
  input logic              mode_load,
  input logic [NPORTS-1:0] busy
);

  // R1
  reset_val_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> cfg_rdata_o == {REGW{strap_auto_i}});

  // R8
  one_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(start_o));

  // R7
  mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_load |=> cfg_rdata_o == {REGW{$past(mode_i[1])}});

  for (genvar p = 0; p < NPORTS; p++) begin : g_chk
    // R9
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_o[p] |=> !start_o[p]);

    // R9
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_o[p] |-> busy[p] && !$past(busy[p]));

    // R3
    det_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_o[p] && !start_cls_o[p]) |-> $past(cfg_rdata_o[p]));

    // R4
    cls_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_cls_o[p] |-> start_o[p] && $past(cfg_rdata_o[NPORTS+p]));
  end

endmodule

bind probe_sched probe_sched_chk #(.NPORTS(NPORTS)) u_probe_sched_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .strap_auto_i (strap_auto_i),
  .mode_i       (mode_i),
  .cfg_rdata_o  (cfg_rdata_o),
  .start_o      (start_o),
  .start_cls_o  (start_cls_o),
  .mode_load    (mode_load),
  .busy         (busy)
);

// File: tb/probe_sched_bench.sv
`timescale 1ns/1ps
module probe_sched_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strap = 1'b1;
  logic [1:0] mode = 2'b10;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic [3:0] start_o, start_cls_o;
  logic [3:0] done_r = 4'h0;
  logic [3:0] spur = 4'h0;
  logic [3:0] done_i;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;
  assign done_i = done_r | spur;

  probe_sched u_probe_sched (
    .clk          (clk),
    .rst_n        (rst_n),
    .strap_auto_i (strap),
    .mode_i       (mode),
    .cfg_we_i     (cfg_we),
    .cfg_wdata_i  (cfg_wdata),
    .cfg_rdata_o  (cfg_rdata),
    .start_o      (start_o),
    .start_cls_o  (start_cls_o),
    .done_i       (done_i)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  bit [3:0] mdet, mcls, mbusy, mcur, mnxt, mpend, mpd, mpc, mst, mstc;
  int mrr, mmode;
  bit mseen;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdet = {4{strap}}; mcls = {4{strap}};
      mbusy = 0; mcur = 0; mnxt = 0; mpend = 0; mpd = 0; mpc = 0;
      mst = 0; mstc = 0; mrr = 3; mmode = 0; mseen = 0;
    end else begin
      int g;
      bit ld, lv, man;
      bit [3:0] ndet, ncls, nnxt;
      g = -1;
      for (int k = 1; k <= 4; k++) begin
        int i;
        i = (mrr + k) % 4;
        if (g < 0 && !mbusy[i] && (mdet[i] || mcls[i])) g = i;
      end
      ld  = mseen && (int'(mode) != mmode);
      lv  = mode[1];
      man = (mode == 2'b00);
      mst = 0; mstc = 0;
      ndet = mdet; ncls = mcls; nnxt = mnxt;
      for (int p = 0; p < 4; p++) begin
        bit fin, kind;
        fin  = mbusy[p] && done_i[p];
        kind = mcls[p] && (!mdet[p] || mnxt[p]);
        if (fin) begin
          nnxt[p] = !mcur[p];
          if (man) begin
            if (mcur[p]) ncls[p] = 0; else ndet[p] = 0;
          end
          if (mpend[p]) begin ndet[p] = mpd[p]; ncls[p] = mpc[p]; nnxt[p] = 0; end
        end
        if (cfg_we && (!mbusy[p] || fin)) begin
          ndet[p] = cfg_wdata[p]; ncls[p] = cfg_wdata[4+p]; nnxt[p] = 0;
        end
        if (ld) begin ndet[p] = lv; ncls[p] = lv; nnxt[p] = 0; end
        if (ld) mpend[p] = 0;
        else if (cfg_we && mbusy[p] && !fin) begin
          mpend[p] = 1; mpd[p] = cfg_wdata[p]; mpc[p] = cfg_wdata[4+p];
        end else if (fin) mpend[p] = 0;
        if (g == p) begin
          mst[p] = 1; mstc[p] = kind; mbusy[p] = 1; mcur[p] = kind;
        end else if (fin) mbusy[p] = 0;
      end
      if (g >= 0) mrr = g;
      mdet = ndet; mcls = ncls; mnxt = nnxt;
      mmode = int'(mode); mseen = 1;
    end
  end

  // ---------------- engine, tallies and per-cycle compare ----------------
  int cnt [4];
  int lat [4] = '{2, 3, 1, 4};
  int ndet_st [4];
  int ncls_st [4];

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < 4; p++) cnt[p] = 0;
      done_r <= 4'h0;
    end else begin
      // R2: live register value
      check(cfg_rdata == {mcls, mdet}, "R2 register", cfg_rdata, {mcls, mdet});
      // R8: start issue timing and order
      check(start_o == mst, "R8 start", start_o, mst);
      // R3: routine kind
      check(start_cls_o == mstc, "R3 kind", start_cls_o, mstc);
      for (int p = 0; p < 4; p++) begin
        done_r[p] <= 1'b0;
        if (cnt[p] > 0) begin
          cnt[p]--;
          if (cnt[p] == 0) done_r[p] <= 1'b1;
        end
        if (start_o[p]) begin
          cnt[p] = lat[p];
          if (start_cls_o[p]) ncls_st[p]++; else ndet_st[p]++;
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic wr(input logic [7:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_start(input int p, output bit got, output bit kind);
    got = 0; kind = 0;
    for (int i = 0; i < 50 && !got; i++) begin
      @(negedge clk);
      if (start_o[p]) begin got = 1; kind = start_cls_o[p]; end
    end
  endtask

  task automatic wait_reg(input logic [7:0] exp, input string tag);
    for (int i = 0; i < 60 && cfg_rdata != exp; i++) @(negedge clk);
    check(cfg_rdata == exp, tag, cfg_rdata, exp);
  endtask

  initial begin
    bit got, kind;
    int d0, c0, prev, seen_n;
    for (int p = 0; p < 4; p++) begin ndet_st[p] = 0; ncls_st[p] = 0; end

    // Reset with strap high in auto mode
    repeat (3) @(negedge clk);
    check(cfg_rdata == 8'hFF, "R1 reset value", cfg_rdata, 8'hFF);
    check(start_o == 4'h0, "R1 no start in reset", start_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(start_o == 4'b0001, "R8 port0 first", start_o, 4'b0001);
    check(start_cls_o == 4'b0000, "R3 detection first", start_cls_o, 0);
    repeat (40) @(negedge clk);
    check(cfg_rdata == 8'hFF, "R6 auto bits kept", cfg_rdata, 8'hFF);
    check(ndet_st[0] > 1 && ncls_st[0] > 0, "R6 auto alternation", ncls_st[0], 1);

    // Semi mode
    mode = 2'b01;
    @(negedge clk);
    check(cfg_rdata == 8'h00, "R7 semi loads zero", cfg_rdata, 0);
    repeat (10) @(negedge clk);
    wr(8'h0F);
    d0 = ndet_st[1];
    repeat (30) @(negedge clk);
    check(cfg_rdata == 8'h0F, "R6 semi bits kept", cfg_rdata, 8'h0F);
    check(ndet_st[1] > d0 + 1, "R6 semi reissue", ndet_st[1], d0 + 2);

    // Manual mode
    mode = 2'b00;
    @(negedge clk);
    check(cfg_rdata == 8'h00, "R7 manual loads zero", cfg_rdata, 0);
    repeat (10) @(negedge clk);
    spur = 4'hF;
    @(negedge clk);
    spur = 4'h0;
    check(cfg_rdata == 8'h00, "R9 idle done ignored", cfg_rdata, 0);
    check(start_o == 4'h0, "R9 idle done no start", start_o, 0);

    wr(8'h01);
    wait_start(0, got, kind);
    check(got && !kind, "R5 pushbutton detection start", {got, kind}, 2'b10);
    wait_reg(8'h00, "R5 detection bit cleared");

    wr(8'h20);
    wait_start(1, got, kind);
    check(got && kind, "R4 classification only", {got, kind}, 2'b11);
    wait_reg(8'h00, "R5 classification bit cleared");

    wr(8'h44);
    wait_start(2, got, kind);
    check(got && !kind, "R3 detection before classification", {got, kind}, 2'b10);
    wait_start(2, got, kind);
    check(got && kind, "R3 classification after detection", {got, kind}, 2'b11);
    wait_reg(8'h00, "R5 both bits cleared");

    // Deferred write
    wr(8'h08);
    wait_start(3, got, kind);
    wr(8'h88);
    check(cfg_rdata == 8'h08, "R10 write held while busy", cfg_rdata, 8'h08);
    wait_start(3, got, kind);
    check(cfg_rdata == 8'h88, "R10 write applied at done", cfg_rdata, 8'h88);
    wait_reg(8'h00, "R10 deferred routines complete");

    // Round robin
    wr(8'h0F);
    prev = -1; seen_n = 0; c0 = 0;
    for (int i = 0; i < 20 && seen_n < 4; i++) begin
      @(negedge clk);
      for (int p = 0; p < 4; p++) if (start_o[p]) begin
        if (prev >= 0 && p != (prev + 1) % 4) c0++;
        prev = p; seen_n++;
      end
    end
    check(seen_n == 4 && c0 == 0, "R8 round-robin order", c0, 0);
    wait_reg(8'h00, "R5 all pushbuttons cleared");

    // Load beats write
    mode = 2'b10; cfg_we = 1'b1; cfg_wdata = 8'h00;
    @(negedge clk);
    cfg_we = 1'b0;
    check(cfg_rdata == 8'hFF, "R7 load over write", cfg_rdata, 8'hFF);
    repeat (10) @(negedge clk);

    // Reset into manual with strap high: first edge must not load
    rst_n = 1'b0; strap = 1'b1; mode = 2'b00;
    repeat (2) @(negedge clk);
    check(cfg_rdata == 8'hFF, "R1 strap reset value", cfg_rdata, 8'hFF);
    rst_n = 1'b1;
    @(negedge clk);
    check(cfg_rdata == 8'hFF, "R7 no load at first edge", cfg_rdata, 8'hFF);
    check(start_o == 4'b0001, "R8 port0 first after reset", start_o, 4'b0001);
    repeat (20) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule